// File: doc/BRIEF.md
# Bit-test branch execution unit

This block is the execute stage that a small 8-bit processor uses for its bit-test branches and its counted loops. The decoder hands it one operation, an operand class, a bit index, a signed 8-bit displacement, the program counter of the instruction and the operand address. The unit reads the operand through a shared byte port that can insert wait states. It decides whether the branch is taken and writes the operand back when the operation requires it. After the instruction's cycle budget has elapsed, it reports the next program counter.

There are four operations. Two branch on the selected bit being one or being zero. One branches on a one and then clears that bit. The last decrements a byte and branches while the result is nonzero. The target is always relative to the end of the instruction, so the unit also knows the encoded length of every form. A one-cycle done strobe lets the surrounding pipeline resume after the correct number of cycles.

Top module: `bit_branch_unit`

## Requirements
- R1: Operation code 0 (branch if set) is taken when bit `bit_i` of the operand is 1. The next PC is pc_i + length + the sign-extended displacement when taken, and pc_i + length otherwise, both modulo 2^16.
- R2: Operation code 1 (branch if clear) is taken when the selected bit is 0. It uses the same target arithmetic as R1.
- R3: Operation code 2 (test and clear) is taken when the selected bit is 1. In that case it issues exactly one write of the byte it read, with only that bit forced to 0. When the bit is 0 it issues no write.
- R4: Operation code 3 (loop) writes back the operand minus 1, so 0x00 becomes 0xFF. It is taken when that result is nonzero.
- R5: The operand class codes are 0 direct RAM, 1 special register, 2 accumulator, 3 status word, 4 HL-indirect, 5 register B and 6 register C. The instruction length is 2 for B and C, 3 for accumulator, HL and loop-on-RAM, and 4 for special register. For direct RAM and status word it is 3 with code 0 and 4 with codes 1 and 2.
- R6: With no wait states, done rises exactly N clock edges after the edge that accepts start. N is 8 for the accumulator and for code 0 on RAM. It is 10 for codes 1 and 2 on RAM and for internal HL. It is 11 for codes 0 and 1 on a special register, and 12 for code 2 on a special register. On the status word it is 9 for code 0, 11 for code 1 and 12 for code 2. It is 6 for the B/C loop and 8 for the RAM loop.
- R7: When `far_i` is 1, the HL form takes 11 cycles for codes 0 and 1 and 12 cycles for code 2, before waits are added.
- R8: Each cycle in which `mem_ready` is low during a read or write holds that access, with its class and address unchanged. Each such cycle delays done by one cycle.
- R9: done is high for exactly one cycle. `busy` is low in that cycle. `taken` and `pc_next` are valid then and stay unchanged afterwards while no new start arrives.
- R10: Codes 0 and 1 never write. The status word, and with it the flags, is written only by code 2 when its bit is 1.
- R11: After reset the unit is idle: no read, no write, done low and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new instruction when idle |
| op_i | input | 2 | Operation code |
| cls_i | input | 3 | Operand class code |
| far_i | input | 1 | HL operand lies in the external expansion area |
| bit_i | input | 3 | Bit index |
| disp_i | input | 8 | Signed branch displacement |
| pc_i | input | 16 | Address of the instruction |
| addr_i | input | 16 | Operand address |
| mem_rd | output | 1 | Operand read request |
| mem_wr | output | 1 | Operand write request |
| mem_cls | output | 3 | Class of the accessed operand |
| mem_addr | output | 16 | Operand address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, taken when ready is high |
| mem_ready | input | 1 | Access completes in this cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion strobe |
| taken | output | 1 | Branch decision |
| pc_next | output | 16 | Next program counter |

## Verification
The assertions take for granted that start only carries legal pairings. The four bit operations go with classes 0 to 4, and the loop goes with class 0, 5 or 6. They also assume that `mem_rdata` is valid in the cycle a read completes. The bench issues only these pairings and raises start only while the unit is idle. Its responder returns the prepared byte on every read cycle and lowers ready only for the counted number of wait cycles of each access.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

    localparam int DATA_W = 8;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int LEN_W  = 3;
    localparam int CYC_W  = 5;

    typedef enum logic [1:0] {
        OP_BSET = 2'd0,
        OP_BCLR = 2'd1,
        OP_BTCL = 2'd2,
        OP_LOOP = 2'd3
    } bop_e;

    typedef enum logic [2:0] {
        CL_RAM  = 3'd0,
        CL_SFR  = 3'd1,
        CL_ACC  = 3'd2,
        CL_PSW  = 3'd3,
        CL_HL   = 3'd4,
        CL_REGB = 3'd5,
        CL_REGC = 3'd6,
        CL_NONE = 3'd7
    } bcls_e;

    typedef struct packed {
        bop_e              op;
        bcls_e             cls;
        logic              far;
        logic [BIT_W-1:0]  bsel;
        logic [DATA_W-1:0] disp;
    } instr_t;

    function automatic logic legal_pair(bop_e op, bcls_e cls);
        if (op == OP_LOOP)
            return (cls == CL_RAM) || (cls == CL_REGB) || (cls == CL_REGC);
        return (cls == CL_RAM) || (cls == CL_SFR) || (cls == CL_ACC) ||
               (cls == CL_PSW) || (cls == CL_HL);
    endfunction

    function automatic logic [LEN_W-1:0] instr_len(bop_e op, bcls_e cls);
        case (cls)
            CL_REGB, CL_REGC: return LEN_W'(2);
            CL_ACC, CL_HL:    return LEN_W'(3);
            CL_SFR:           return LEN_W'(4);
            CL_RAM:           return (op == OP_BSET || op == OP_LOOP) ? LEN_W'(3) : LEN_W'(4);
            CL_PSW:           return (op == OP_BSET) ? LEN_W'(3) : LEN_W'(4);
            default:          return LEN_W'(1);
        endcase
    endfunction

    function automatic logic [CYC_W-1:0] base_cycles(bop_e op, bcls_e cls, logic far);
        case (cls)
            CL_ACC:           return CYC_W'(8);
            CL_REGB, CL_REGC: return CYC_W'(6);
            CL_RAM:           return (op == OP_BSET || op == OP_LOOP) ? CYC_W'(8) : CYC_W'(10);
            CL_SFR:           return (op == OP_BTCL) ? CYC_W'(12) : CYC_W'(11);
            CL_PSW: begin
                if (op == OP_BSET) return CYC_W'(9);
                return (op == OP_BTCL) ? CYC_W'(12) : CYC_W'(11);
            end
            CL_HL: begin
                if (!far) return CYC_W'(10);
                return (op == OP_BTCL) ? CYC_W'(12) : CYC_W'(11);
            end
            default:          return CYC_W'(6);
        endcase
    endfunction

endpackage

// File: rtl/bbr_cost.sv
module bbr_cost
    import bbr_pkg::*;
(
    input  bop_e             op,
    input  bcls_e            cls,
    input  logic             far,
    output logic [LEN_W-1:0] len,
    output logic [CYC_W-1:0] cycles
);
    always_comb begin
        len    = instr_len(op, cls);
        cycles = base_cycles(op, cls, far);
    end
endmodule

// File: rtl/bbr_eval.sv
module bbr_eval
    import bbr_pkg::*;
(
    input  bop_e              op,
    input  logic [BIT_W-1:0]  bsel,
    input  logic [DATA_W-1:0] rdata,
    output logic              take,
    output logic              wr_need,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] dec_val;
    logic              sel_bit;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign keep_mask[g] = (bsel != BIT_W'(g));
    end

    assign sel_bit = rdata[bsel];
    assign dec_val = rdata - DATA_W'(1);

    always_comb begin
        take    = 1'b0;
        wr_need = 1'b0;
        wdata   = rdata;
        case (op)
            OP_BSET: take = sel_bit;
            OP_BCLR: take = !sel_bit;
            OP_BTCL: begin
                take    = sel_bit;
                wr_need = sel_bit;
                wdata   = rdata & keep_mask;
            end
            OP_LOOP: begin
                wr_need = 1'b1;
                wdata   = dec_val;
                take    = (dec_val != '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bbr_target.sv
module bbr_target
    import bbr_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] disp,
    input  logic              take,
    output logic [PC_W-1:0]   nxt
);
    logic [PC_W-1:0] fall_through;
    logic [PC_W-1:0] disp_ext;

    assign fall_through = pc + PC_W'(len);
    assign disp_ext     = {{(PC_W-DATA_W){disp[DATA_W-1]}}, disp};
    assign nxt          = take ? fall_through + disp_ext : fall_through;
endmodule

// File: rtl/bbr_seq.sv
module bbr_seq
    import bbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ready,
    input  logic [CYC_W-1:0] total,
    input  logic             wr_need,
    output logic             rd,
    output logic             wr,
    output logic             cap,
    output logic             busy,
    output logic             done
);
    typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_WAIT} st_e;

    st_e              state;
    logic [CYC_W-1:0] cnt;
    logic [CYC_W-1:0] cnt_nx;

    assign cnt_nx = cnt + CYC_W'(1);
    assign rd     = (state == S_READ);
    assign wr     = (state == S_WRITE);
    assign cap    = rd && ready;
    assign busy   = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    state <= S_READ;
                    cnt   <= '0;
                end
                S_READ: if (ready) begin
                    cnt   <= cnt_nx;
                    state <= wr_need ? S_WRITE : S_WAIT;
                end
                S_WRITE: if (ready) begin
                    cnt   <= cnt_nx;
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    cnt <= cnt_nx;
                    if (cnt_nx == total) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9: completion strobe lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a stalled read stays requested
    assert_hold_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd && !ready) |=> rd);

    // R8: a stalled write stays requested
    assert_hold_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && !ready) |=> wr);

    // R3: a write only ever follows a completed read
    assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(wr) |-> $past(rd));

    // R6: the cycle counter never passes the budget
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < total));
endmodule

// File: rtl/bit_branch_unit.sv
module bit_branch_unit
    import bbr_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_i,
    input  logic [2:0]        cls_i,
    input  logic              far_i,
    input  logic [2:0]        bit_i,
    input  logic [7:0]        disp_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [2:0]        mem_cls,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [PC_W-1:0]   pc_next
);
    instr_t            ins_in;
    instr_t            ins_q;
    logic [PC_W-1:0]   pc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_in;
    logic [LEN_W-1:0]  len_q;
    logic [CYC_W-1:0]  cyc_in;
    logic [CYC_W-1:0]  total_q;
    logic              take_c;
    logic              wr_need_c;
    logic [DATA_W-1:0] wdata_c;
    logic [DATA_W-1:0] wdata_q;
    logic [PC_W-1:0]   nxt_c;
    logic              cap;
    logic              accept;

    assign ins_in.op   = bop_e'(op_i);
    assign ins_in.cls  = bcls_e'(cls_i);
    assign ins_in.far  = far_i;
    assign ins_in.bsel = bit_i;
    assign ins_in.disp = disp_i;
    assign accept      = start && !busy;

    bbr_cost u_cost (
        .op     (ins_in.op),
        .cls    (ins_in.cls),
        .far    (ins_in.far),
        .len    (len_in),
        .cycles (cyc_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q   <= '0;
            pc_q    <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            total_q <= CYC_W'(6);
        end else if (accept) begin
            ins_q   <= ins_in;
            pc_q    <= pc_i;
            addr_q  <= addr_i;
            len_q   <= len_in;
            total_q <= cyc_in;
        end
    end

    bbr_eval u_eval (
        .op      (ins_q.op),
        .bsel    (ins_q.bsel),
        .rdata   (mem_rdata),
        .take    (take_c),
        .wr_need (wr_need_c),
        .wdata   (wdata_c)
    );

    bbr_target #(.PC_W(PC_W)) u_target (
        .pc   (pc_q),
        .len  (len_q),
        .disp (ins_q.disp),
        .take (take_c),
        .nxt  (nxt_c)
    );

    bbr_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ready   (mem_ready),
        .total   (total_q),
        .wr_need (wr_need_c),
        .rd      (mem_rd),
        .wr      (mem_wr),
        .cap     (cap),
        .busy    (busy),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken   <= 1'b0;
            pc_next <= '0;
            wdata_q <= '0;
        end else if (cap) begin
            taken   <= take_c;
            pc_next <= nxt_c;
            wdata_q <= wdata_c;
        end
    end

    assign mem_cls   = ins_q.cls;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    // R5: only legal operation/class pairings are offered
    assert_legal_pair_R5: assert property (@(posedge clk) disable iff (rst)
        accept |-> legal_pair(ins_in.op, ins_in.cls));

    // R10: the pure test forms never write
    assert_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (ins_q.op == OP_BTCL || ins_q.op == OP_LOOP));

    // R3: test-and-clear writes only after a taken test, with its bit cleared
    assert_clear_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && ins_q.op == OP_BTCL) |-> (taken && !mem_wdata[ins_q.bsel]));

    // R8: a stalled access keeps its class and address
    assert_stable_addr_R8: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_cls)));

    // R1: an untaken branch falls through to the end of the instruction
    assert_fall_through_R1: assert property (@(posedge clk) disable iff (rst)
        (done && !taken) |-> (pc_next == pc_q + PC_W'(len_q)));

    // R9: the unit is idle while done is shown
    assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/test_bit_branch_unit.sv
`timescale 1ns/1ps
module test_bit_branch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_i = '0;
    logic [2:0]  cls_i = '0;
    logic        far_i = 1'b0;
    logic [2:0]  bit_i = '0;
    logic [7:0]  disp_i = '0;
    logic [15:0] pc_i = '0;
    logic [15:0] addr_i = '0;
    logic        mem_rd, mem_wr;
    logic [2:0]  mem_cls;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b1;
    logic        busy, done, taken;
    logic [15:0] pc_next;

    int total = 0;
    int bad = 0;
    int rd_left = 0, wr_left = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [7:0]  wr_data;
    logic [2:0]  wr_cls, rd_cls;
    logic [15:0] rd_addr;

    always #10 clk = ~clk;

    bit_branch_unit i_bit_branch_unit (
        .clk(clk), .rst(rst), .start(start), .op_i(op_i), .cls_i(cls_i),
        .far_i(far_i), .bit_i(bit_i), .disp_i(disp_i), .pc_i(pc_i),
        .addr_i(addr_i), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_cls(mem_cls),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .taken(taken),
        .pc_next(pc_next)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // responder: ready, wait insertion and access logging
    initial begin
        forever begin
            @(negedge clk);
            mem_ready = 1'b1;
            if (mem_rd) begin
                if (rd_left > 0) begin mem_ready = 1'b0; rd_left--; end
                else begin rd_cnt++; rd_cls = mem_cls; rd_addr = mem_addr; end
            end else if (mem_wr) begin
                if (wr_left > 0) begin mem_ready = 1'b0; wr_left--; end
                else begin wr_cnt++; wr_data = mem_wdata; wr_cls = mem_cls; end
            end
        end
    end

    function automatic int exp_len(int op, int cls);
        if (cls == 5 || cls == 6) return 2;
        if (cls == 2 || cls == 4) return 3;
        if (cls == 1) return 4;
        if (op == 0 || op == 3) return 3;
        return 4;
    endfunction

    function automatic int exp_cyc(int op, int cls, int far);
        case (cls)
            2: return 8;
            5, 6: return 6;
            0: return (op == 0 || op == 3) ? 8 : 10;
            1: return (op == 2) ? 12 : 11;
            3: return (op == 0) ? 9 : ((op == 2) ? 12 : 11);
            default: return (far == 0) ? 10 : ((op == 2) ? 12 : 11);
        endcase
    endfunction

    task automatic run(input int op, input int cls, input int far, input int b,
                       input logic [7:0] disp, input logic [15:0] pc,
                       input logic [7:0] data, input int n, input int m);
        int cyc;
        int bitv, tk, wr_exp, exp_c, len;
        logic [7:0]  wd;
        logic [15:0] pcx, addr;
        logic        tk_hold;
        logic [15:0] pc_hold;
        addr = 16'hFE00 + 16'(b * 17 + cls);
        @(negedge clk);
        op_i = 2'(op); cls_i = 3'(cls); far_i = far[0]; bit_i = 3'(b);
        disp_i = disp; pc_i = pc; addr_i = addr; mem_rdata = data;
        rd_left = n; wr_left = m; wr_cnt = 0; rd_cnt = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        bitv = data[b];
        wd = data;
        case (op)
            0: begin tk = bitv; wr_exp = 0; end
            1: begin tk = 1 - bitv; wr_exp = 0; end
            2: begin tk = bitv; wr_exp = bitv; wd[b] = 1'b0; end
            default: begin wd = data - 8'd1; tk = (wd != 0) ? 1 : 0; wr_exp = 1; end
        endcase
        len = exp_len(op, cls);
        pcx = pc + 16'(len);
        if (tk != 0) pcx = pcx + {{8{disp[7]}}, disp};
        exp_c = exp_cyc(op, cls, far) + n + (wr_exp != 0 ? m : 0);
        if (cls == 4 && far != 0)
            chk(cyc == exp_c, "R7 ext cycles", cyc, exp_c);
        else if (n + m > 0)
            chk(cyc == exp_c, "R8 wait cycles", cyc, exp_c);
        else
            chk(cyc == exp_c, "R6 cycles", cyc, exp_c);
        case (op)
            0: chk(taken == tk[0], "R1 taken", int'(taken), tk);
            1: chk(taken == tk[0], "R2 taken", int'(taken), tk);
            2: chk(taken == tk[0], "R3 taken", int'(taken), tk);
            default: chk(taken == tk[0], "R4 taken", int'(taken), tk);
        endcase
        chk(pc_next == pcx, "R1 R5 next pc", int'(pc_next), int'(pcx));
        chk(rd_cnt == 1 && rd_cls == 3'(cls) && rd_addr == addr, "R8 read access",
            int'(rd_addr), int'(addr));
        if (op < 2) chk(wr_cnt == 0, "R10 no write", wr_cnt, 0);
        else if (op == 2) chk(wr_cnt == wr_exp, "R3 write count", wr_cnt, wr_exp);
        else chk(wr_cnt == 1, "R4 write count", wr_cnt, 1);
        if (wr_exp != 0 && wr_cnt == 1) begin
            if (op == 2) chk(wr_data == wd && wr_cls == 3'(cls), "R3 write data", int'(wr_data), int'(wd));
            else chk(wr_data == wd && wr_cls == 3'(cls), "R4 write data", int'(wr_data), int'(wd));
        end
        chk(done && !busy, "R9 idle at done", int'(busy), 0);
        tk_hold = taken; pc_hold = pc_next;
        @(negedge clk);
        chk(!done && taken == tk_hold && pc_next == pc_hold, "R9 pulse and hold",
            int'(done), 0);
    endtask

    initial begin
        logic [7:0] dtab [8];
        logic [7:0] vtab [5];
        int         ctab [5];
        dtab = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF, 8'h10, 8'hF0};
        vtab = '{8'h00, 8'h01, 8'h02, 8'h80, 8'hFF};
        ctab = '{0, 1, 2, 3, 4};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R11 reset idle",
            int'({busy, done, mem_rd, mem_wr}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R11 after reset",
            int'({busy, done, mem_rd, mem_wr}), 0);
        // bit operations over every class, bit, data pattern and far setting
        for (int op = 0; op < 3; op++)
            for (int ci = 0; ci < 5; ci++)
                for (int far = 0; far < 2; far++)
                    if (far == 0 || ctab[ci] == 4)
                        for (int b = 0; b < 8; b++)
                            for (int d = 0; d < 2; d++)
                                run(op, ctab[ci], far, b, dtab[b],
                                    (b % 2 == 1) ? 16'hFFFC : 16'h1234,
                                    (d == 0) ? 8'h5A : 8'hA5, 0, 0);
        // loop form on RAM, B and C, including wrap from 0x00
        for (int c = 0; c < 3; c++)
            for (int v = 0; v < 5; v++)
                run(3, (c == 0) ? 0 : c + 4, 0, 0, dtab[v + 3], 16'h0002, vtab[v], 0, 0);
        // wait states on external HL reads and writes
        for (int op = 0; op < 3; op++)
            for (int n = 0; n < 4; n++)
                for (int m = 0; m < 4; m++)
                    run(op, 4, 1, 3, 8'hF8, 16'h4000, 8'hFF, n, m);
        // waits on other classes and on the loop write
        run(3, 0, 0, 0, 8'hFE, 16'h0100, 8'h05, 2, 1);
        run(2, 3, 0, 6, 8'h03, 16'h0200, 8'h40, 1, 3);
        run(0, 1, 0, 2, 8'h80, 16'h0300, 8'h04, 3, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule